// File: doc/BRIEF.md
# Two-Wire Register Slave for a Temperature Monitor

This block is the serial front end of a temperature monitor. It sits on a two-wire bus (clock line and open-drain data line) as a slave. It answers a 7-bit address whose upper four bits are a fixed device identifier and whose lower three bits come from strap pins. Behind the bus it keeps four registers, selected by a two-bit pointer: a read-only temperature word loaded from the sensing logic, an 8-bit settings byte, and a lower and an upper 16-bit trip threshold. The settings and thresholds leave the block on ports, where the thermostat logic uses them.

Bus lines are sampled through a short synchronizer and edge detector inside the block's own clock domain. The block must therefore run at least eight times faster than the bus clock. The data line is modelled as a sampled input plus an output enable that pulls the wire low. The block does not stretch the bus clock. It issues a one-cycle strobe each time a read transaction starts returning register data, so that an interrupt-style output elsewhere can be cleared on a read. A write address followed by the command byte 0x54 restores every register and the pointer to their power-up state. A watchdog on the block's own drive releases the data line if it has been held low for too long.

Top module: `thermo_i2c_regslave`

## Requirements
- R1: The block acknowledges only the address byte whose top seven bits are 1001 followed by the three strap bits (bit 0 is read=1/write=0); any other address gets no acknowledge, and the block then stays off the data line until the next START or STOP.
- R2: The byte after a write address is a pointer byte with six zero upper bits and a two-bit selector: 00 temperature, 01 settings, 10 lower threshold, 11 upper threshold. A pointer byte with any upper bit set, other than the reset command, is not acknowledged and leaves the pointer unchanged.
- R3: The pointer is 00 after reset. Read transactions do not change it, so repeated reads without a pointer byte return the same register.
- R4: After the pointer byte, a settings write takes one data byte, and a threshold write takes two, most significant byte first. The threshold is updated only once its second byte is received. Every accepted data byte is acknowledged. Surplus bytes, and any data byte sent to the temperature register, are not acknowledged and have no effect.
- R5: A 16-bit register is read most significant byte first, then least significant byte. A master NACK after the first byte ends the data. The settings register returns one byte, and the line stays released (0xFF) if the master asks for more.
- R6: The byte 0x54 directly after a write address is not acknowledged. It returns the settings to 0x00, the thresholds to their defaults, the temperature word to 0x0000 and the pointer to 00.
- R7: Bit 7 of the settings register accepts writes but always reads and outputs as 0.
- R8: Bits 3:0 of the temperature word and of both thresholds always read as 0, whatever was written or loaded.
- R9: If the block itself has driven the data line low for TIMEOUT_CYCLES consecutive clock cycles, it releases the line and returns to idle. The data line held low by another device never triggers this.
- R10: A repeated START after a pointer write, followed by a read address, returns data from the newly selected register.
- R11: `reg_read_o` pulses high for exactly one cycle per read transaction, when the first data byte is loaded for sending.
- R12: After reset the data line is released, settings read 0x00, the lower threshold reads 0x4B00 and the upper threshold 0x5000.
- R13: Both bytes of one 16-bit read come from one snapshot taken when the first byte is loaded, even if the temperature word is reloaded between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, at least 8x the bus clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| addr_strap_i | input | 3 | Low three bits of the slave address |
| temp_i | input | 16 | Temperature word from the sensing logic |
| temp_load_i | input | 1 | Loads temp_i into the temperature register |
| cfg_o | output | 8 | Settings register, bit 7 always 0 |
| trip_lo_o | output | 16 | Lower trip threshold |
| trip_hi_o | output | 16 | Upper trip threshold |
| reg_read_o | output | 1 | One-cycle strobe when a read returns register data |

## Verification
Every bus edge passes through two synchronizer flops and an edge-compare flop. The data-line drive therefore changes on the third clock edge after the bus clock falls. The bench drives each bit for 8 cycles low and 8 cycles high, and samples the wire in the middle of the high phase, well past that delay. Register outputs take effect one edge after the byte-completing clock fall, so they are compared only after the STOP, tens of cycles later. The timeout is checked at half the window (still driven) and at 1.2 windows (released) from the clock fall that began the acknowledge.

// File: rtl/thermo_i2c_pkg.sv
package thermo_i2c_pkg;

   localparam int REG_W      = 16;
   localparam int BYTE_W     = 8;
   localparam int ZERO_LSBS  = 4;
   localparam logic [BYTE_W-1:0] SOFT_RESET_CMD = 8'h54;

   typedef enum logic [1:0] {
      SEL_TEMP = 2'b00,
      SEL_CFG  = 2'b01,
      SEL_TLO  = 2'b10,
      SEL_THI  = 2'b11
   } reg_sel_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_SACK,
      ST_TX,
      ST_MACK,
      ST_HOLD
   } link_st_e;

   typedef enum logic [1:0] {
      RX_ADDR,
      RX_PTR,
      RX_DATA
   } rx_kind_e;

endpackage

// File: rtl/thermo_i2c_sync.sv
module thermo_i2c_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det,
   output logic sda_s
);

   logic [STAGES-1:0] scl_ff;
   logic [STAGES-1:0] sda_ff;
   logic              scl_p;
   logic              sda_p;
   logic              scl_s;

   initial begin
      assert (STAGES >= 2) else $error("thermo_i2c_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_ff <= '1;
         sda_ff <= '1;
         scl_p  <= 1'b1;
         sda_p  <= 1'b1;
      end else begin
         scl_ff <= {scl_ff[STAGES-2:0], scl_i};
         sda_ff <= {sda_ff[STAGES-2:0], sda_i};
         scl_p  <= scl_s;
         sda_p  <= sda_s;
      end
   end

   assign scl_s     = scl_ff[STAGES-1];
   assign sda_s     = sda_ff[STAGES-1];
   assign scl_rise  = scl_s & ~scl_p;
   assign scl_fall  = ~scl_s & scl_p;
   assign start_det = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/thermo_i2c_regs.sv
module thermo_i2c_regs
   import thermo_i2c_pkg::*;
#(
   parameter logic [REG_W-1:0] TRIP_LO_DEF = 16'h4B00,
   parameter logic [REG_W-1:0] TRIP_HI_DEF = 16'h5000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic [REG_W-1:0] temp_i,
   input  logic             temp_load,
   input  reg_sel_e         rd_sel,
   output logic [REG_W-1:0] rd_word,
   input  logic             wr_en,
   input  reg_sel_e         wr_sel,
   input  logic [REG_W-1:0] wr_data,
   output logic [BYTE_W-1:0] cfg_o,
   output logic [REG_W-1:0] trip_lo_o,
   output logic [REG_W-1:0] trip_hi_o
);

   localparam int TRIP_N = 2;
   localparam int CFG_W  = BYTE_W - 1;

   logic [REG_W-1:0] temp_q;
   logic [CFG_W-1:0] cfg_q;
   logic             unused_ok;

   assign unused_ok = ^{temp_i[ZERO_LSBS-1:0], wr_data[ZERO_LSBS-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         temp_q <= '0;
      end else if (soft_rst) begin
         temp_q <= '0;
      end else if (temp_load) begin
         temp_q <= {temp_i[REG_W-1:ZERO_LSBS], {ZERO_LSBS{1'b0}}};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (soft_rst) begin
         cfg_q <= '0;
      end else if (wr_en && wr_sel == SEL_CFG) begin
         cfg_q <= wr_data[CFG_W-1:0];
      end
   end

   for (genvar t = 0; t < TRIP_N; t++) begin : g_trip
      localparam logic [REG_W-1:0] DEF = (t == 0) ? TRIP_LO_DEF : TRIP_HI_DEF;
      localparam reg_sel_e         SEL = (t == 0) ? SEL_TLO : SEL_THI;
      logic [REG_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= DEF;
         end else if (soft_rst) begin
            q <= DEF;
         end else if (wr_en && wr_sel == SEL) begin
            q <= {wr_data[REG_W-1:ZERO_LSBS], {ZERO_LSBS{1'b0}}};
         end
      end
   end

   assign trip_lo_o = g_trip[0].q;
   assign trip_hi_o = g_trip[1].q;
   assign cfg_o     = {1'b0, cfg_q};

   always_comb begin
      unique case (rd_sel)
         SEL_TEMP: rd_word = temp_q;
         SEL_CFG:  rd_word = {1'b0, cfg_q, {BYTE_W{1'b0}}};
         SEL_TLO:  rd_word = trip_lo_o;
         default:  rd_word = trip_hi_o;
      endcase
   end

   AST_SOFT_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (cfg_o == '0 && trip_lo_o == TRIP_LO_DEF && trip_hi_o == TRIP_HI_DEF)); // R6

   AST_TRIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en || soft_rst) |=> ($stable(trip_lo_o) && $stable(trip_hi_o))); // R4

   AST_CFG_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel == SEL_CFG) |-> (rd_word[REG_W-1] == 1'b0)); // R7

endmodule

// File: rtl/thermo_i2c_link.sv
module thermo_i2c_link
   import thermo_i2c_pkg::*;
#(
   parameter logic [3:0]  DEV_ID         = 4'b1001,
   parameter int unsigned TIMEOUT_CYCLES = 25_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              sda_s,
   input  logic [2:0]        strap,
   input  logic [REG_W-1:0]  rd_word,
   output reg_sel_e          ptr_o,
   output logic              wr_en,
   output logic [REG_W-1:0]  wr_data,
   output logic              soft_rst,
   output logic              rd_strobe,
   output logic              sda_oe
);

   localparam int TO_W = $clog2(TIMEOUT_CYCLES + 1);
   localparam logic [TO_W-1:0] TO_LAST = TO_W'(TIMEOUT_CYCLES - 1);

   link_st_e          state;
   rx_kind_e          kind;
   rx_kind_e          nxt_kind;
   reg_sel_e          ptr_q;
   logic [3:0]        bit_cnt;
   logic [1:0]        data_idx;
   logic [BYTE_W-1:0] sh;
   logic [BYTE_W-1:0] tx;
   logic [BYTE_W-1:0] ls_hold;
   logic [BYTE_W-1:0] ms_hold;
   logic              ack_to_tx;
   logic              mack_ok;
   logic              rd_second;
   logic              oe_q;
   logic [TO_W-1:0]   to_cnt;

   initial begin
      assert (TIMEOUT_CYCLES >= 16) else $error("thermo_i2c_link: TIMEOUT_CYCLES too small");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         kind      <= RX_ADDR;
         nxt_kind  <= RX_ADDR;
         ptr_q     <= SEL_TEMP;
         bit_cnt   <= '0;
         data_idx  <= '0;
         sh        <= '0;
         tx        <= '1;
         ls_hold   <= '0;
         ms_hold   <= '0;
         ack_to_tx <= 1'b0;
         mack_ok   <= 1'b0;
         rd_second <= 1'b0;
         oe_q      <= 1'b0;
         to_cnt    <= '0;
         wr_en     <= 1'b0;
         wr_data   <= '0;
         soft_rst  <= 1'b0;
         rd_strobe <= 1'b0;
      end else begin
         wr_en     <= 1'b0;
         soft_rst  <= 1'b0;
         rd_strobe <= 1'b0;
         if (oe_q) to_cnt <= to_cnt + 1'b1;
         else      to_cnt <= '0;

         if (oe_q && to_cnt == TO_LAST) begin
            state  <= ST_IDLE;
            oe_q   <= 1'b0;
            to_cnt <= '0;
         end else if (start_det) begin
            state     <= ST_RX;
            kind      <= RX_ADDR;
            bit_cnt   <= '0;
            oe_q      <= 1'b0;
            rd_second <= 1'b0;
         end else if (stop_det) begin
            state <= ST_IDLE;
            oe_q  <= 1'b0;
         end else begin
            unique case (state)
               ST_RX: begin
                  if (scl_rise) begin
                     sh      <= {sh[BYTE_W-2:0], sda_s};
                     bit_cnt <= bit_cnt + 4'd1;
                  end else if (scl_fall && bit_cnt == 4'd8) begin
                     state <= ST_HOLD;
                     unique case (kind)
                        RX_ADDR: begin
                           if (sh[BYTE_W-1:1] == {DEV_ID, strap}) begin
                              oe_q      <= 1'b1;
                              state     <= ST_SACK;
                              ack_to_tx <= sh[0];
                              nxt_kind  <= RX_PTR;
                           end
                        end
                        RX_PTR: begin
                           if (sh == SOFT_RESET_CMD) begin
                              soft_rst <= 1'b1;
                              ptr_q    <= SEL_TEMP;
                           end else if (sh[BYTE_W-1:2] == '0) begin
                              ptr_q     <= reg_sel_e'(sh[1:0]);
                              oe_q      <= 1'b1;
                              state     <= ST_SACK;
                              ack_to_tx <= 1'b0;
                              nxt_kind  <= RX_DATA;
                              data_idx  <= '0;
                           end
                        end
                        default: begin
                           if ((ptr_q == SEL_CFG && data_idx == 2'd0) ||
                               ((ptr_q == SEL_TLO || ptr_q == SEL_THI) && data_idx == 2'd1)) begin
                              wr_en   <= 1'b1;
                              wr_data <= (ptr_q == SEL_CFG) ? {{BYTE_W{1'b0}}, sh} : {ms_hold, sh};
                           end
                           if ((ptr_q == SEL_TLO || ptr_q == SEL_THI) && data_idx == 2'd0) begin
                              ms_hold <= sh;
                           end
                           if ((ptr_q == SEL_CFG && data_idx == 2'd0) ||
                               ((ptr_q == SEL_TLO || ptr_q == SEL_THI) && data_idx < 2'd2)) begin
                              oe_q      <= 1'b1;
                              state     <= ST_SACK;
                              ack_to_tx <= 1'b0;
                              nxt_kind  <= RX_DATA;
                              data_idx  <= data_idx + 2'd1;
                           end
                        end
                     endcase
                  end
               end
               ST_SACK: begin
                  if (scl_fall) begin
                     bit_cnt <= '0;
                     if (ack_to_tx) begin
                        tx        <= rd_word[REG_W-1:BYTE_W];
                        ls_hold   <= rd_word[BYTE_W-1:0];
                        oe_q      <= ~rd_word[REG_W-1];
                        rd_strobe <= 1'b1;
                        rd_second <= 1'b0;
                        state     <= ST_TX;
                     end else begin
                        oe_q  <= 1'b0;
                        kind  <= nxt_kind;
                        state <= ST_RX;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     bit_cnt <= bit_cnt + 4'd1;
                  end else if (scl_fall) begin
                     if (bit_cnt == 4'd8) begin
                        oe_q  <= 1'b0;
                        state <= ST_MACK;
                     end else begin
                        tx   <= {tx[BYTE_W-2:0], 1'b1};
                        oe_q <= ~tx[BYTE_W-2];
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     mack_ok <= ~sda_s;
                  end else if (scl_fall) begin
                     if (mack_ok && !rd_second && ptr_q != SEL_CFG) begin
                        tx        <= ls_hold;
                        oe_q      <= ~ls_hold[BYTE_W-1];
                        bit_cnt   <= '0;
                        rd_second <= 1'b1;
                        state     <= ST_TX;
                     end else begin
                        state <= ST_HOLD;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign ptr_o  = ptr_q;
   assign sda_oe = oe_q;

   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe |=> !rd_strobe); // R11

   AST_TIMEOUT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_q && to_cnt == TO_LAST) |=> (!oe_q && state == ST_IDLE)); // R9

   AST_START_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (start_det && !(oe_q && to_cnt == TO_LAST)) |=> (!oe_q && state == ST_RX && kind == RX_ADDR)); // R10

   AST_PTR_ONLY_IN_RX: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_RX) |=> $stable(ptr_q)); // R3

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE || state == ST_HOLD) |-> !oe_q); // R1

endmodule

// File: rtl/thermo_i2c_regslave.sv
module thermo_i2c_regslave
   import thermo_i2c_pkg::*;
#(
   parameter logic [3:0]       DEV_ID         = 4'b1001,
   parameter int               SYNC_STAGES    = 2,
   parameter int unsigned      TIMEOUT_CYCLES = 25_000_000,
   parameter logic [REG_W-1:0] TRIP_LO_DEF    = 16'h4B00,
   parameter logic [REG_W-1:0] TRIP_HI_DEF    = 16'h5000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        scl_i,
   input  logic        sda_i,
   output logic        sda_oe_o,
   input  logic [2:0]  addr_strap_i,
   input  logic [15:0] temp_i,
   input  logic        temp_load_i,
   output logic [7:0]  cfg_o,
   output logic [15:0] trip_lo_o,
   output logic [15:0] trip_hi_o,
   output logic        reg_read_o
);

   logic             scl_rise;
   logic             scl_fall;
   logic             start_det;
   logic             stop_det;
   logic             sda_s;
   reg_sel_e         ptr;
   logic [REG_W-1:0] rd_word;
   logic             wr_en;
   logic [REG_W-1:0] wr_data;
   logic             soft_rst;

   initial begin
      assert (TRIP_LO_DEF[ZERO_LSBS-1:0] == '0 && TRIP_HI_DEF[ZERO_LSBS-1:0] == '0)
         else $error("thermo_i2c_regslave: trip defaults must have zero low bits");
   end

   thermo_i2c_sync #(
      .STAGES(SYNC_STAGES)
   ) i_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .sda_s     (sda_s)
   );

   thermo_i2c_link #(
      .DEV_ID         (DEV_ID),
      .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
   ) i_link (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .sda_s     (sda_s),
      .strap     (addr_strap_i),
      .rd_word   (rd_word),
      .ptr_o     (ptr),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .soft_rst  (soft_rst),
      .rd_strobe (reg_read_o),
      .sda_oe    (sda_oe_o)
   );

   thermo_i2c_regs #(
      .TRIP_LO_DEF (TRIP_LO_DEF),
      .TRIP_HI_DEF (TRIP_HI_DEF)
   ) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_rst  (soft_rst),
      .temp_i    (temp_i),
      .temp_load (temp_load_i),
      .rd_sel    (ptr),
      .rd_word   (rd_word),
      .wr_en     (wr_en),
      .wr_sel    (ptr),
      .wr_data   (wr_data),
      .cfg_o     (cfg_o),
      .trip_lo_o (trip_lo_o),
      .trip_hi_o (trip_hi_o)
   );

endmodule

// File: tb/test_thermo_i2c_regslave.sv
`timescale 1ns/1ps
module test_thermo_i2c_regslave;

   localparam int TOUT = 300;
   localparam int HALF = 8;
   localparam logic [7:0] AW = 8'h9A;
   localparam logic [7:0] AR = 8'h9B;
   localparam logic [7:0] ABAD = 8'h9C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic        sda_line;
   logic        sda_oe;
   logic [15:0] temp_v = 16'h0000;
   logic        temp_ld = 1'b0;
   logic [7:0]  cfg;
   logic [15:0] tlo;
   logic [15:0] thi;
   logic        rd_stb;

   int n_tests = 0;
   int n_fail  = 0;
   int strobes = 0;
   int exp_strobes = 0;

   always #2 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   thermo_i2c_regslave #(.TIMEOUT_CYCLES(TOUT)) i_thermo_i2c_regslave (
      .clk          (clk),
      .rst_n        (rst_n),
      .scl_i        (scl_m),
      .sda_i        (sda_line),
      .sda_oe_o     (sda_oe),
      .addr_strap_i (3'b101),
      .temp_i       (temp_v),
      .temp_load_i  (temp_ld),
      .cfg_o        (cfg),
      .trip_lo_o    (tlo),
      .trip_hi_o    (thi),
      .reg_read_o   (rd_stb)
   );

   always @(posedge clk) if (rst_n && rd_stb) strobes++;

   task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input logic b, output logic seen);
      sda_m = b;
      wait_cyc(HALF);
      scl_m = 1'b1;
      wait_cyc(HALF / 2);
      seen = sda_line;
      wait_cyc(HALF / 2);
      scl_m = 1'b0;
      wait_cyc(2);
   endtask

   task automatic bus_start();
      sda_m = 1'b1;
      wait_cyc(HALF);
      scl_m = 1'b1;
      wait_cyc(HALF);
      sda_m = 1'b0;
      wait_cyc(HALF);
      scl_m = 1'b0;
      wait_cyc(2);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0;
      wait_cyc(HALF);
      scl_m = 1'b1;
      wait_cyc(HALF);
      sda_m = 1'b1;
      wait_cyc(HALF);
   endtask

   task automatic wr_byte(input logic [7:0] b, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) pulse(b[i], s);
      pulse(1'b1, s);
      ack = ~s;
   endtask

   task automatic rd_byte(input logic m_ack, output logic [7:0] v);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         pulse(1'b1, s);
         v[i] = s;
      end
      pulse(~m_ack, s);
   endtask

   task automatic read_cur(input logic two, output logic [15:0] v);
      logic a;
      logic [7:0] hi, lo;
      bus_start();
      wr_byte(AR, a);
      check("R1", "read address ack", 16'(a), 16'h1);
      rd_byte(two, hi);
      lo = 8'h00;
      if (two) rd_byte(1'b0, lo);
      bus_stop();
      exp_strobes++;
      v = {hi, lo};
   endtask

   task automatic read_ptr(input logic [1:0] p, input logic two, output logic [15:0] v);
      logic a;
      logic [7:0] hi, lo;
      bus_start();
      wr_byte(AW, a);
      wr_byte({6'b0, p}, a);
      check("R2", "pointer ack", 16'(a), 16'h1);
      bus_start();
      wr_byte(AR, a);
      rd_byte(two, hi);
      lo = 8'h00;
      if (two) rd_byte(1'b0, lo);
      bus_stop();
      exp_strobes++;
      v = {hi, lo};
   endtask

   task automatic write_reg(input logic [1:0] p, input int nb, input logic [15:0] d, output logic [2:0] acks);
      logic a;
      bus_start();
      wr_byte(AW, a);
      wr_byte({6'b0, p}, a);
      acks = 3'b000;
      if (nb >= 1) begin wr_byte((nb == 1) ? d[7:0] : d[15:8], a); acks[0] = a; end
      if (nb >= 2) begin wr_byte(d[7:0], a); acks[1] = a; end
      if (nb >= 3) begin wr_byte(8'h11, a); acks[2] = a; end
      bus_stop();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] v;
      logic [2:0]  acks;
      logic        a;
      logic        s;
      logic [7:0]  b;

      wait_cyc(5);
      rst_n = 1'b1;
      wait_cyc(5);
      // R12 reset state
      check("R12", "sda_oe after reset", 16'(sda_oe), 16'h0);
      check("R12", "cfg after reset", 16'(cfg), 16'h0000);
      check("R12", "trip_lo after reset", tlo, 16'h4B00);
      check("R12", "trip_hi after reset", thi, 16'h5000);

      temp_v = 16'h1912; temp_ld = 1'b1; wait_cyc(1); temp_ld = 1'b0;
      // R3 default pointer, R5 byte order, R8 low nibble zero
      read_cur(1'b1, v);
      check("R3", "default pointer reads temperature", v, 16'h1910);
      check("R11", "strobe count after first read", 16'(strobes), 16'(exp_strobes));

      // R1 foreign address
      bus_start();
      wr_byte(ABAD, a);
      check("R1", "foreign address not acked", 16'(a), 16'h0);
      pulse(1'b1, s);
      check("R1", "line released after foreign address", 16'(s), 16'h1);
      bus_stop();

      // R4 settings write, R7 top bit
      write_reg(2'b01, 1, 16'h00FF, acks);
      check("R4", "settings byte acked", 16'(acks[0]), 16'h1);
      check("R7", "settings top bit output", 16'(cfg), 16'h007F);
      // R10 repeated start read
      read_ptr(2'b01, 1'b0, v);
      check("R10", "settings via repeated start", v[15:8], 8'h7F);
      // R5 settings read is one byte
      read_cur(1'b1, v);
      check("R5", "settings first byte", v[15:8], 8'h7F);
      check("R5", "settings extra byte released", v[7:0], 8'hFF);

      // R8 threshold masking
      write_reg(2'b10, 2, 16'h1234, acks);
      check("R4", "lower threshold acks", 16'(acks[1:0]), 16'h3);
      check("R8", "lower threshold low bits", tlo, 16'h1230);
      write_reg(2'b11, 3, 16'h7777, acks);
      check("R4", "upper threshold acks", 16'(acks[1:0]), 16'h3);
      check("R4", "surplus byte nacked", 16'(acks[2]), 16'h0);
      check("R4", "upper threshold value", thi, 16'h7770);
      write_reg(2'b10, 1, 16'h00AA, acks);
      check("R4", "single threshold byte acked", 16'(acks[0]), 16'h1);
      check("R4", "half threshold write no effect", tlo, 16'h1230);

      // R4 write to temperature refused
      write_reg(2'b00, 1, 16'h0055, acks);
      check("R4", "temperature write nacked", 16'(acks[0]), 16'h0);
      read_cur(1'b1, v);
      check("R4", "temperature unchanged", v, 16'h1910);

      // R2 invalid pointer
      bus_start();
      wr_byte(AW, a);
      wr_byte(8'h05, a);
      check("R2", "invalid pointer nacked", 16'(a), 16'h0);
      bus_stop();
      read_cur(1'b1, v);
      check("R2", "pointer unchanged after invalid", v, 16'h1910);

      read_ptr(2'b11, 1'b1, v);
      check("R10", "upper threshold via repeated start", v, 16'h7770);
      read_cur(1'b1, v);
      check("R3", "sticky pointer on second read", v, 16'h7770);

      // R13 snapshot
      write_reg(2'b00, 0, 16'h0000, acks);
      bus_start();
      wr_byte(AR, a);
      rd_byte(1'b1, b);
      check("R13", "snapshot MS byte", 16'(b), 16'h0019);
      temp_v = 16'h2468; temp_ld = 1'b1; wait_cyc(1); temp_ld = 1'b0;
      rd_byte(1'b0, b);
      check("R13", "snapshot LS byte", 16'(b), 16'h0010);
      bus_stop();
      exp_strobes++;
      read_cur(1'b1, v);
      check("R13", "new temperature after reload", v, 16'h2460);

      // R6 soft reset
      write_reg(2'b11, 0, 16'h0000, acks);
      bus_start();
      wr_byte(AW, a);
      wr_byte(8'h54, a);
      check("R6", "reset command not acked", 16'(a), 16'h0);
      bus_stop();
      wait_cyc(4);
      check("R6", "settings after soft reset", 16'(cfg), 16'h0000);
      check("R6", "lower threshold after soft reset", tlo, 16'h4B00);
      check("R6", "upper threshold after soft reset", thi, 16'h5000);
      read_cur(1'b1, v);
      check("R6", "pointer and temperature after soft reset", v, 16'h0000);
      check("R11", "strobe count after all reads", 16'(strobes), 16'(exp_strobes));

      // R9 timeout on own drive
      bus_start();
      for (int i = 7; i >= 0; i--) pulse(AW[i], s);
      wait_cyc(TOUT / 2);
      check("R9", "still driving at half window", 16'(sda_oe), 16'h1);
      wait_cyc(TOUT * 7 / 10);
      check("R9", "released after window", 16'(sda_oe), 16'h0);
      bus_stop();

      // R9 another device holding the line low
      bus_start();
      sda_m = 1'b0;
      wait_cyc(TOUT * 2);
      wr_byte(AW, a);
      check("R9", "foreign low hold does not reset", 16'(a), 16'h1);
      wr_byte(8'h01, a);
      bus_stop();

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule